// File: doc/BRIEF.md
# Memory-Subsystem Command Mailbox Register Slave

This block is the device-side register window of a command mailbox for a memory subsystem. A host on a simple 32-bit register bus first loads up to seven parameter words. It then writes one command-request word, and that write starts a command. The block passes the four decoded request fields and all parameter words to a back-end executor over a valid/ready port. It then waits for the executor's one-cycle response pulse.

The block captures the response into a status word and three response data words, and it raises a ready flag. The status word also carries a general error code, a command error code and a 16-bit short result. The host reads the results and then writes the ready flag back to zero. That write also zeroes the request word, and a zero request word is how the host sees that the mailbox can take a new command. Writing the request word while it is non-zero breaks the protocol. Such a write is dropped, and a sticky error bit records it.

Top module: `mbox_regif`

## Requirements
- R1: After reset, every mapped register reads zero and `cmdValid` is low.
- R2: Parameter word i (i = 0..6) lives at byte offset 0x438 - 4*i. It reads back what was last written, keeps its value across commands when it is not rewritten, and is presented on `cmdParams[32*i +: 32]`.
- R3: A non-zero write to the request word (offset 0x43C) while it reads zero raises `cmdValid` in the following cycle. The request fields are presented as IP type = bits 31:29, instance ID = bits 28:24, command type = bits 23:16 and opcode = bits 15:0. The command stays stable while `cmdReady` is low, and `cmdValid` drops after the cycle in which `cmdReady` is high.
- R4: From the accepting write until retirement, the request word reads back the written non-zero value.
- R5: A write to the request word while it is non-zero leaves the request and the executor port untouched. It sets sticky status bit 8, which only reset clears.
- R6: A `rspValid` pulse after the handshake sets status bit 0 (ready) and loads status bits 4:1 from `rspGenErr`, bits 7:5 from `rspCmdErr` and bits 31:16 from `rspShort`. Response data word j (from `rspData[32*j +: 32]`) reads at offset 0x458 - 4*j. Status bits 15:9 read zero. Launching a command clears ready, both error codes, the short result and all response data.
- R7: A `rspValid` pulse when no handshaken command is waiting changes no register.
- R8: A status write (offset 0x45C) with bit 0 = 0 while ready is set clears ready, zeroes the request word and lets a new command be accepted. A status write with bit 0 = 1 has no effect.
- R9: Reads of unmapped offsets return zero.
- R10: Writing zero to an idle request word launches nothing.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous active-low reset |
| regWr | input | 1 | Register write strobe |
| regAddr | input | 12 | Byte address of register access |
| regWdata | input | 32 | Write data |
| regRdata | output | 32 | Read data for `regAddr` (combinational) |
| cmdValid | output | 1 | Command offered to executor |
| cmdReady | input | 1 | Executor accepts command |
| cmdIpType | output | 3 | Target IP type field |
| cmdInstId | output | 5 | Target instance ID field |
| cmdType | output | 8 | Command type field |
| cmdOpcode | output | 16 | Opcode field |
| cmdParams | output | 224 | Parameter words, word i at bits 32*i+31:32*i |
| rspValid | input | 1 | Executor response pulse |
| rspGenErr | input | 4 | General error code |
| rspCmdErr | input | 3 | Command response error code |
| rspShort | input | 16 | Short response value |
| rspData | input | 96 | Response data words, word j at bits 32*j+31:32*j |

## Verification
The bench builds the block with its default seven parameter words and three response words. This makes every mapped offset reachable, including the lowest parameter slot at 0x420 and the last response word at 0x450. The random exchanges rewrite only some parameter slots between commands, so retention is exercised. They vary the executor's accept latency, inject busy-time request writes and pulse stray responses in idle. The gaps around the mapped windows (0x41C, 0x440 to 0x44C) are probed for zero reads.

// File: rtl/mbox_pkg.sv
package mbox_pkg;
  localparam int unsigned OFS_REQ    = 'h43C;
  localparam int unsigned OFS_PARAM0 = 'h438;
  localparam int unsigned OFS_STATUS = 'h45C;
  localparam int unsigned OFS_RSP0   = 'h458;
  localparam int unsigned WORD_STEP  = 4;

  localparam int unsigned REQ_IPTYPE_LSB = 29;
  localparam int unsigned REQ_INST_LSB   = 24;
  localparam int unsigned REQ_TYPE_LSB   = 16;

  typedef enum logic [1:0] {ST_IDLE, ST_LAUNCH, ST_WAIT, ST_DONE} mboxState_t;

  typedef struct packed {
    logic reqLoad;
    logic reqClear;
    logic rspClear;
    logic rspLoad;
    logic protoErrSet;
  } mboxStrobe_t;

  function automatic int unsigned paramOfs(int unsigned idx);
    return OFS_PARAM0 - WORD_STEP * idx;
  endfunction

  function automatic int unsigned rspOfs(int unsigned idx);
    return OFS_RSP0 - WORD_STEP * idx;
  endfunction
endpackage

// File: rtl/mbox_ctrl.sv
module mbox_ctrl
  import mbox_pkg::*;
#(
  parameter int ADDR_W = 12
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              regWr,
  input  logic [ADDR_W-1:0] regAddr,
  input  logic              wdataNonZero,
  input  logic              wdataReadyBit,
  input  logic              reqBusy,
  input  logic              cmdReady,
  input  logic              rspValid,
  output logic              cmdValid,
  output mboxStrobe_t       strobe
);
  localparam logic [ADDR_W-1:0] REQ_A    = ADDR_W'(OFS_REQ);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(OFS_STATUS);

  mboxState_t state, nextState;
  logic hitReq, hitStatus;

  assign hitReq    = regWr && (regAddr == REQ_A);
  assign hitStatus = regWr && (regAddr == STATUS_A);

  always_comb begin
    strobe    = '0;
    nextState = state;
    strobe.protoErrSet = hitReq && reqBusy;
    case (state)
      ST_IDLE: begin
        if (hitReq && !reqBusy && wdataNonZero) begin
          strobe.reqLoad  = 1'b1;
          strobe.rspClear = 1'b1;
          nextState       = ST_LAUNCH;
        end
      end
      ST_LAUNCH: if (cmdReady) nextState = ST_WAIT;
      ST_WAIT: begin
        if (rspValid) begin
          strobe.rspLoad = 1'b1;
          nextState      = ST_DONE;
        end
      end
      ST_DONE: begin
        if (hitStatus && !wdataReadyBit) begin
          strobe.reqClear = 1'b1;
          nextState       = ST_IDLE;
        end
      end
      default: nextState = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) state <= ST_IDLE;
    else       state <= nextState;
  end

  assign cmdValid = (state == ST_LAUNCH);
endmodule

// File: rtl/mbox_dp.sv
module mbox_dp
  import mbox_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int DW      = 32,
  parameter int N_PARAM = 7,
  parameter int N_RSP   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  mboxStrobe_t           strobe,
  input  logic                  regWr,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [DW-1:0]         regWdata,
  output logic [DW-1:0]         regRdata,
  input  logic [3:0]            rspGenErr,
  input  logic [2:0]            rspCmdErr,
  input  logic [15:0]           rspShort,
  input  logic [N_RSP*DW-1:0]   rspData,
  output logic [DW-1:0]         reqWord,
  output logic                  readyFlag,
  output logic                  protoErr,
  output logic [N_PARAM*DW-1:0] paramFlat
);
  localparam logic [ADDR_W-1:0] REQ_A    = ADDR_W'(OFS_REQ);
  localparam logic [ADDR_W-1:0] STATUS_A = ADDR_W'(OFS_STATUS);
  localparam int PAD_W = DW - 16 - 9;

  logic [DW-1:0] paramQ [N_PARAM];
  logic [DW-1:0] rspQ   [N_RSP];
  logic [3:0]    genErrQ;
  logic [2:0]    cmdErrQ;
  logic [15:0]   shortQ;
  logic [DW-1:0] statusWord;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < N_PARAM; i++) paramQ[i] <= '0;
    end else if (regWr) begin
      for (int i = 0; i < N_PARAM; i++)
        if (regAddr == ADDR_W'(paramOfs(i))) paramQ[i] <= regWdata;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      reqWord <= '0;
      protoErr <= 1'b0;
    end else begin
      if (strobe.reqLoad)       reqWord <= regWdata;
      else if (strobe.reqClear) reqWord <= '0;
      if (strobe.protoErrSet)   protoErr <= 1'b1;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      readyFlag <= 1'b0;
      genErrQ   <= '0;
      cmdErrQ   <= '0;
      shortQ    <= '0;
      for (int j = 0; j < N_RSP; j++) rspQ[j] <= '0;
    end else if (strobe.rspLoad) begin
      readyFlag <= 1'b1;
      genErrQ   <= rspGenErr;
      cmdErrQ   <= rspCmdErr;
      shortQ    <= rspShort;
      for (int j = 0; j < N_RSP; j++) rspQ[j] <= rspData[j*DW +: DW];
    end else if (strobe.rspClear) begin
      readyFlag <= 1'b0;
      genErrQ   <= '0;
      cmdErrQ   <= '0;
      shortQ    <= '0;
      for (int j = 0; j < N_RSP; j++) rspQ[j] <= '0;
    end else if (strobe.reqClear) begin
      readyFlag <= 1'b0;
    end
  end

  assign statusWord = {shortQ, {PAD_W{1'b0}}, protoErr, cmdErrQ, genErrQ, readyFlag};

  always_comb begin
    regRdata = '0;
    if (regAddr == REQ_A)    regRdata = reqWord;
    if (regAddr == STATUS_A) regRdata = statusWord;
    for (int i = 0; i < N_PARAM; i++)
      if (regAddr == ADDR_W'(paramOfs(i))) regRdata = paramQ[i];
    for (int j = 0; j < N_RSP; j++)
      if (regAddr == ADDR_W'(rspOfs(j))) regRdata = rspQ[j];
  end

  for (genvar g = 0; g < N_PARAM; g++) begin : gParamOut
    assign paramFlat[g*DW +: DW] = paramQ[g];
  end
endmodule

// File: rtl/mbox_regif.sv
module mbox_regif
  import mbox_pkg::*;
#(
  parameter int ADDR_W  = 12,
  parameter int N_PARAM = 7,
  parameter int N_RSP   = 3
) (
  input  logic                  clk,
  input  logic                  rstN,
  input  logic                  regWr,
  input  logic [ADDR_W-1:0]     regAddr,
  input  logic [31:0]           regWdata,
  output logic [31:0]           regRdata,
  output logic                  cmdValid,
  input  logic                  cmdReady,
  output logic [2:0]            cmdIpType,
  output logic [4:0]            cmdInstId,
  output logic [7:0]            cmdType,
  output logic [15:0]           cmdOpcode,
  output logic [N_PARAM*32-1:0] cmdParams,
  input  logic                  rspValid,
  input  logic [3:0]            rspGenErr,
  input  logic [2:0]            rspCmdErr,
  input  logic [15:0]           rspShort,
  input  logic [N_RSP*32-1:0]   rspData
);
  mboxStrobe_t strobe;
  logic [31:0] reqWord;
  logic readyFlag, protoErr;

  mbox_ctrl #(.ADDR_W(ADDR_W)) u_ctrl (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr),
    .wdataNonZero(|regWdata), .wdataReadyBit(regWdata[0]),
    .reqBusy(|reqWord), .cmdReady(cmdReady), .rspValid(rspValid),
    .cmdValid(cmdValid), .strobe(strobe)
  );

  mbox_dp #(.ADDR_W(ADDR_W), .DW(32), .N_PARAM(N_PARAM), .N_RSP(N_RSP)) u_dp (
    .clk(clk), .rstN(rstN), .strobe(strobe), .regWr(regWr), .regAddr(regAddr),
    .regWdata(regWdata), .regRdata(regRdata), .rspGenErr(rspGenErr),
    .rspCmdErr(rspCmdErr), .rspShort(rspShort), .rspData(rspData),
    .reqWord(reqWord), .readyFlag(readyFlag), .protoErr(protoErr),
    .paramFlat(cmdParams)
  );

  assign cmdIpType = reqWord[31:REQ_IPTYPE_LSB];
  assign cmdInstId = reqWord[REQ_IPTYPE_LSB-1:REQ_INST_LSB];
  assign cmdType   = reqWord[REQ_INST_LSB-1:REQ_TYPE_LSB];
  assign cmdOpcode = reqWord[REQ_TYPE_LSB-1:0];
endmodule

// File: rtl/mbox_regif_chk.sv
module mbox_regif_chk (
  input logic        clk,
  input logic        rstN,
  input logic        cmdValid,
  input logic        cmdReady,
  input logic [31:0] cmdFields,
  input logic [31:0] reqWord,
  input logic        readyFlag,
  input logic        protoErr,
  input logic        rspValid
);
  // R4: a command on offer is backed by a busy request word
  p_busy_on_launch_r4: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> (reqWord != 32'd0));

  // R4: a pending response keeps the request word busy
  p_busy_on_ready_r4: assert property (@(posedge clk) disable iff (!rstN)
    readyFlag |-> (reqWord != 32'd0));

  // R3: command held stable until accepted
  p_hold_until_ready_r3: assert property (@(posedge clk) disable iff (!rstN)
    (cmdValid && !cmdReady) |=> (cmdValid && $stable(cmdFields)));

  // R6: ready only rises after a response pulse
  p_ready_from_rsp_r6: assert property (@(posedge clk) disable iff (!rstN)
    $rose(readyFlag) |-> $past(rspValid));

  // R6: no response while the command is still on offer
  p_no_ready_in_launch_r6: assert property (@(posedge clk) disable iff (!rstN)
    cmdValid |-> !readyFlag);

  // R5: protocol error bit is sticky
  p_sticky_proto_r5: assert property (@(posedge clk) disable iff (!rstN)
    protoErr |=> protoErr);
endmodule

bind mbox_regif mbox_regif_chk u_chk (
  .clk(clk), .rstN(rstN), .cmdValid(cmdValid), .cmdReady(cmdReady),
  .cmdFields({cmdIpType, cmdInstId, cmdType, cmdOpcode}),
  .reqWord(reqWord), .readyFlag(readyFlag), .protoErr(protoErr),
  .rspValid(rspValid)
);

// File: tb/tb_mbox_regif.sv
`timescale 1ns/1ps
module tb_mbox_regif;
  localparam int NP = 7;
  localparam int NR = 3;
  localparam logic [11:0] A_REQ = 12'h43C;
  localparam logic [11:0] A_ST  = 12'h45C;

  logic clk = 1'b0;
  logic rstN = 1'b0;
  logic regWr = 1'b0;
  logic [11:0] regAddr = '0;
  logic [31:0] regWdata = '0;
  logic [31:0] regRdata;
  logic cmdValid, cmdReady = 1'b0;
  logic [2:0] cmdIpType;
  logic [4:0] cmdInstId;
  logic [7:0] cmdType;
  logic [15:0] cmdOpcode;
  logic [NP*32-1:0] cmdParams;
  logic rspValid = 1'b0;
  logic [3:0] rspGenErr = '0;
  logic [2:0] rspCmdErr = '0;
  logic [15:0] rspShort = '0;
  logic [NR*32-1:0] rspData = '0;

  int total = 0, bad = 0;
  bit finished = 0;
  logic [31:0] expParam [NP];
  logic [31:0] expRsp [NR];
  logic [31:0] expStat;
  bit sticky = 0;

  always #10 clk = ~clk;

  mbox_regif dut (
    .clk(clk), .rstN(rstN), .regWr(regWr), .regAddr(regAddr), .regWdata(regWdata),
    .regRdata(regRdata), .cmdValid(cmdValid), .cmdReady(cmdReady),
    .cmdIpType(cmdIpType), .cmdInstId(cmdInstId), .cmdType(cmdType),
    .cmdOpcode(cmdOpcode), .cmdParams(cmdParams), .rspValid(rspValid),
    .rspGenErr(rspGenErr), .rspCmdErr(rspCmdErr), .rspShort(rspShort),
    .rspData(rspData)
  );

  function automatic logic [11:0] pAddr(int i); return 12'h438 - 12'(4*i); endfunction
  function automatic logic [11:0] rAddr(int j); return 12'h458 - 12'(4*j); endfunction
  function automatic logic [31:0] mkStat(bit rdy, logic [3:0] g, logic [2:0] c, bit st,
                                         logic [15:0] s);
    return {s, 7'd0, st, c, g, rdy};
  endfunction

  task automatic check(string tag, logic [31:0] act, logic [31:0] exp);
    total++;
    if (act !== exp) begin
      bad++;
      $display("FAIL %s act=%h exp=%h", tag, act, exp);
    end
  endtask

  task automatic wr(logic [11:0] a, logic [31:0] d);
    @(negedge clk);
    regWr = 1'b1; regAddr = a; regWdata = d;
    @(negedge clk);
    regWr = 1'b0;
  endtask

  task automatic rd(logic [11:0] a, output logic [31:0] d);
    regAddr = a;
    #1;
    d = regRdata;
  endtask

  task automatic checkParams(string tag);
    logic [31:0] v;
    for (int i = 0; i < NP; i++) begin
      rd(pAddr(i), v);
      check(tag, v, expParam[i]);
    end
  endtask

  task automatic checkRsp(string tag);
    logic [31:0] v;
    rd(A_ST, v); check(tag, v, expStat);
    for (int j = 0; j < NR; j++) begin
      rd(rAddr(j), v);
      check(tag, v, expRsp[j]);
    end
  endtask

  initial begin : watchdog
    repeat (200000) @(posedge clk);
    if (!finished) begin
      total++; bad++;
      $display("FAIL watchdog act=hung exp=done");
      $display("  test done: total=%0d bad=%0d", total, bad);
      $finish;
    end
  end

  initial begin : main
    logic [31:0] v, req;
    int unsigned dummy;
    dummy = $urandom(32'd4242);
    for (int i = 0; i < NP; i++) expParam[i] = '0;
    for (int j = 0; j < NR; j++) expRsp[j] = '0;
    expStat = '0;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    @(negedge clk);

    // R1: reset state
    check("R1 cmdValid", {31'd0, cmdValid}, 32'd0);
    rd(A_REQ, v); check("R1 req", v, 32'd0);
    checkRsp("R1 status/data");
    checkParams("R1 params");

    // R9: unmapped offsets
    foreach (v[k]) begin end
    rd(12'h000, v); check("R9 0x000", v, 32'd0);
    rd(12'h41C, v); check("R9 0x41C", v, 32'd0);
    rd(12'h440, v); check("R9 0x440", v, 32'd0);
    rd(12'h44C, v); check("R9 0x44C", v, 32'd0);
    rd(12'h460, v); check("R9 0x460", v, 32'd0);

    // R10: zero write launches nothing
    wr(A_REQ, 32'd0);
    check("R10 cmdValid", {31'd0, cmdValid}, 32'd0);
    rd(A_REQ, v); check("R10 req", v, 32'd0);

    // R7: stray response in idle ignored
    @(negedge clk);
    rspValid = 1'b1; rspShort = 16'hBEEF; rspGenErr = 4'hF; rspData = {NR{32'hDEAD0001}};
    @(negedge clk);
    rspValid = 1'b0;
    checkRsp("R7 idle rsp");

    for (int it = 0; it < 40; it++) begin
      int lat;
      // R2: partial parameter rewrites
      for (int i = 0; i < NP; i++) begin
        if ((it == 0) || ($urandom % 2 == 0)) begin
          expParam[i] = $urandom;
          wr(pAddr(i), expParam[i]);
        end
      end
      checkParams("R2 readback");

      req = $urandom;
      if (it == 1) req = 32'hFFFF_FFFF;
      if (it == 2) req = 32'h0000_0001;
      wr(A_REQ, req);
      // R3: launch and field decode
      check("R3 cmdValid", {31'd0, cmdValid}, 32'd1);
      check("R3 fields", {cmdIpType, cmdInstId, cmdType, cmdOpcode}, req);
      for (int i = 0; i < NP; i++) check("R2 cmdParams", cmdParams[i*32 +: 32], expParam[i]);
      expStat = mkStat(0, 0, 0, sticky, 0);
      for (int j = 0; j < NR; j++) expRsp[j] = '0;
      checkRsp("R6 cleared at launch");

      lat = $urandom % 4;
      for (int c = 0; c < lat; c++) begin
        @(negedge clk);
        check("R3 hold valid", {31'd0, cmdValid}, 32'd1);
        check("R3 hold fields", {cmdIpType, cmdInstId, cmdType, cmdOpcode}, req);
      end
      rd(A_REQ, v); check("R4 busy launch", v, req);

      // R5: request write while busy
      if (it % 3 == 0) begin
        wr(A_REQ, $urandom | 32'd1);
        sticky = 1;
        rd(A_REQ, v); check("R5 req kept", v, req);
        rd(A_ST, v); check("R5 sticky bit8", {31'd0, v[8]}, 32'd1);
        check("R5 fields kept", {cmdIpType, cmdInstId, cmdType, cmdOpcode}, req);
      end

      @(negedge clk); cmdReady = 1'b1;
      @(negedge clk); cmdReady = 1'b0;
      check("R3 valid drop", {31'd0, cmdValid}, 32'd0);
      rd(A_REQ, v); check("R4 busy wait", v, req);

      @(negedge clk);
      rspGenErr = 4'($urandom); rspCmdErr = 3'($urandom); rspShort = 16'($urandom);
      for (int j = 0; j < NR; j++) rspData[j*32 +: 32] = $urandom;
      rspValid = 1'b1;
      @(negedge clk);
      rspValid = 1'b0;
      expStat = mkStat(1, rspGenErr, rspCmdErr, sticky, rspShort);
      for (int j = 0; j < NR; j++) expRsp[j] = rspData[j*32 +: 32];
      checkRsp("R6 response");

      // R7: second pulse while done ignored
      rspShort = ~rspShort; rspData = ~rspData;
      rspValid = 1'b1; @(negedge clk); rspValid = 1'b0;
      checkRsp("R7 done rsp");

      // R8: writing 1 has no effect, writing 0 retires
      wr(A_ST, 32'h1);
      rd(A_ST, v); check("R8 no-op write", v, expStat);
      rd(A_REQ, v); check("R8 busy kept", v, req);
      wr(A_ST, 32'h0);
      expStat[0] = 1'b0;
      rd(A_ST, v); check("R8 ready clear", v, expStat);
      rd(A_REQ, v); check("R8 req idle", v, 32'd0);
      checkParams("R2 retained");
    end

    finished = 1;
    $display("  test done: total=%0d bad=%0d", total, bad);
    $finish;
  end
endmodule